// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the register-mapped control point of a processor core module. Software reaches it over a plain 32-bit register bus whose word index is the byte address shifted right by two. Writes take effect on the clock edge in which `bus_sel` and `bus_wr` are both high. Reads are combinational from the presented address while `bus_sel` is high and `bus_wr` is low. The bus never stalls, so there is no back-pressure and no ready pin.

The register set has several parts:

- A 16-bit unlock key. The two oscillator settings can only be changed while the key matches.
- A control word. It drives an LED, selects the boot remap, and can request a system reset.
- Two bit-flag words. Each is changed through separate set and clear addresses.
- A 32-bit up-counter that steps on each cycle in which an external reference tick is high.
- One software interrupt source. It has independent IRQ and FIQ enable masks and a combined interrupt request output.

Top module: `cm_sysctl`

## Requirements
- R1: After reset the block reads as follows. Index 2 (oscillator) reads 0x01000048, index 7 (auxiliary oscillator) reads 0x0007FEFF, index 8 (memory configuration) reads 0x00011122 and index 9 (init) reads 0x00000112. Index 5 reads 0x00010000. Every other index reads zero, and `led_on`, `remap_sel`, `rst_req` and `int_req` are all low.
- R2: A write to index 5 stores bits 15:0 of the data as the key. A read of index 5 returns the key in bits 15:0, with bit 16 set while the key differs from 0xA05F and clear while it equals 0xA05F.
- R3: Writes to index 2 and index 7 replace the whole 32-bit value only while the key equals 0xA05F. Otherwise the value is left unchanged.
- R4: Index 3 stores data bits 0 and 2 and reads back only those two bits. `led_on` equals stored bit 0 and `remap_sel` equals stored bit 2, both visible right after the write edge.
- R5: A write to index 3 with bit 3 set drives `rst_req` high for exactly the one cycle after the write. Bit 3 of index 3 always reads zero.
- R6: Index 12 reads the flag word. A write to index 12 ORs the data into it, and a write to index 13 clears each bit set in the data. Index 14 and index 15 do the same for the second flag word, which reads at index 14.
- R7: Index 10 reads a 32-bit counter that increases by one per clock cycle in which `ref_tick` is high and holds otherwise.
- R8: The IRQ enable mask reads at index 18, gains bits through writes to index 18 and loses bits through writes to index 19. The FIQ mask works the same way at indices 26 and 27.
- R9: The software interrupt level is one bit. A write to index 20 with data bit 0 set raises it, and a write to index 21 with data bit 0 set lowers it. It reads in bit 0 of indices 17, 20 and 25.
- R10: Index 16 reads the level ANDed with the IRQ mask, and index 24 reads the level ANDed with the FIQ mask.
- R11: `int_req` is high exactly when the level is high and bit 0 of either mask is set.
- R12: Index 8 is read-only. Index 9 accepts any 32-bit write. All unlisted indices read zero, and writes to them change nothing readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word index is bits ADDR_W-1:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational; zero when not reading) |
| ref_tick | input | 1 | Reference-rate strobe for the counter |
| led_on | output | 1 | LED drive |
| remap_sel | output | 1 | Boot remap select (1 = flash removed from address 0) |
| rst_req | output | 1 | One-cycle system reset request |
| int_req | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that each bus write is a single-cycle strobe with a stable address. They also assume `ref_tick` is a synchronous level sampled at the clock edge, so that the counter step and the reset pulse can be attributed to the cycle just before. The stimulus drives every input on the falling edge and holds one access per cycle. Random writes never set control bit 3 outside the directed reset-pulse test, which keeps `rst_req` tied to a known write. The counter tick is held low during random traffic so that the counter value the bench expects stays exact.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;
  localparam int DW     = 32;
  localparam int KW     = 16;
  localparam int NIX    = 32;   // decoded word indices
  localparam int NSC    = 4;    // set/clear register pairs

  localparam logic [KW-1:0] OPEN_KEY   = 16'hA05F;
  localparam logic [DW-1:0] OSC_INIT   = 32'h0100_0048;
  localparam logic [DW-1:0] AUX_INIT   = 32'h0007_FEFF;
  localparam logic [DW-1:0] MEMCFG_VAL = 32'h0001_1122;
  localparam logic [DW-1:0] BOOT_INIT  = 32'h0000_0112;

  localparam int IX_OSC     = 2;
  localparam int IX_CTRL    = 3;
  localparam int IX_KEY     = 5;
  localparam int IX_AUX     = 7;
  localparam int IX_MEMCFG  = 8;
  localparam int IX_BOOT    = 9;
  localparam int IX_COUNT   = 10;
  localparam int IX_FLAG    = 12;
  localparam int IX_NVFLAG  = 14;
  localparam int IX_IRQ_ST  = 16;
  localparam int IX_IRQ_RAW = 17;
  localparam int IX_IRQ_EN  = 18;
  localparam int IX_SW_SET  = 20;
  localparam int IX_SW_CLR  = 21;
  localparam int IX_FIQ_ST  = 24;
  localparam int IX_FIQ_RAW = 25;
  localparam int IX_FIQ_EN  = 26;

  // set index of each set/clear pair; the clear index is one above
  function automatic int sc_set_ix(input int k);
    case (k)
      0:       return IX_FLAG;
      1:       return IX_NVFLAG;
      2:       return IX_IRQ_EN;
      default: return IX_FIQ_EN;
    endcase
  endfunction
endpackage

// File: rtl/cm_setclr.sv
module cm_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (set_stb) q <= q | val;
    else if (clr_stb) q <= q & ~val;
  end
endmodule

// File: rtl/cm_keyed_osc.sv
module cm_keyed_osc
  import cm_sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic          osc_wr,
  input  logic          aux_wr,
  input  logic [DW-1:0] wdata,
  output logic [KW-1:0] key_q,
  output logic          open_q,
  output logic [DW-1:0] osc_q,
  output logic [DW-1:0] aux_q
);
  assign open_q = (key_q == OPEN_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      osc_q <= OSC_INIT;
      aux_q <= AUX_INIT;
    end else begin
      if (key_wr)           key_q <= wdata[KW-1:0];
      if (osc_wr && open_q) osc_q <= wdata;
      if (aux_wr && open_q) aux_q <= wdata;
    end
  end
endmodule

// File: rtl/cm_refcount.sv
module cm_refcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
  import cm_sysctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ref_tick,
  output logic              led_on,
  output logic              remap_sel,
  output logic              rst_req,
  output logic              int_req
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]  idx;
  logic           wr_en;
  logic [NIX-1:0] wr_at;
  logic           unused_lowaddr;

  assign idx            = bus_addr[ADDR_W-1:2];
  assign wr_en          = bus_sel & bus_wr;
  assign unused_lowaddr = ^bus_addr[1:0];

  for (genvar g = 0; g < NIX; g++) begin : g_dec
    assign wr_at[g] = wr_en && (idx == IW'(g));
  end

  // keyed oscillator settings
  logic [KW-1:0] key_q;
  logic          lock_open;
  logic [DW-1:0] osc_val, aux_val;

  cm_keyed_osc u_keyed (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_wr (wr_at[IX_KEY]),
    .osc_wr (wr_at[IX_OSC]),
    .aux_wr (wr_at[IX_AUX]),
    .wdata  (bus_wdata),
    .key_q  (key_q),
    .open_q (lock_open),
    .osc_q  (osc_val),
    .aux_q  (aux_val)
  );

  // flags, second flags, IRQ mask, FIQ mask
  logic [DW-1:0] sc_q [NSC];
  for (genvar k = 0; k < NSC; k++) begin : g_sc
    cm_setclr #(.W(DW)) u_sc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (wr_at[sc_set_ix(k)]),
      .clr_stb (wr_at[sc_set_ix(k) + 1]),
      .val     (bus_wdata),
      .q       (sc_q[k])
    );
  end

  // software interrupt level
  logic sw_lvl;
  cm_setclr #(.W(1)) u_swint (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_at[IX_SW_SET]),
    .clr_stb (wr_at[IX_SW_CLR]),
    .val     (bus_wdata[0]),
    .q       (sw_lvl)
  );

  // reference counter
  logic [DW-1:0] cnt_val;
  cm_refcount #(.W(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ref_tick),
    .cnt   (cnt_val)
  );

  // control word, init word, reset pulse
  logic          led_q, remap_q, rst_q;
  logic [DW-1:0] boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q   <= 1'b0;
      remap_q <= 1'b0;
      rst_q   <= 1'b0;
      boot_q  <= BOOT_INIT;
    end else begin
      rst_q <= wr_at[IX_CTRL] & bus_wdata[3];
      if (wr_at[IX_CTRL]) begin
        led_q   <= bus_wdata[0];
        remap_q <= bus_wdata[2];
      end
      if (wr_at[IX_BOOT]) boot_q <= bus_wdata;
    end
  end

  assign led_on    = led_q;
  assign remap_sel = remap_q;
  assign rst_req   = rst_q;

  logic [DW-1:0] lvl_w, irq_st, fiq_st;
  assign lvl_w   = {{(DW-1){1'b0}}, sw_lvl};
  assign irq_st  = lvl_w & sc_q[2];
  assign fiq_st  = lvl_w & sc_q[3];
  assign int_req = sw_lvl & (sc_q[2][0] | sc_q[3][0]);

  // read mux
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (idx)
      IW'(IX_OSC):     rd_mux = osc_val;
      IW'(IX_CTRL):    rd_mux = {{(DW-3){1'b0}}, remap_q, 1'b0, led_q};
      IW'(IX_KEY):     rd_mux = {{(DW-KW-1){1'b0}}, ~lock_open, key_q};
      IW'(IX_AUX):     rd_mux = aux_val;
      IW'(IX_MEMCFG):  rd_mux = MEMCFG_VAL;
      IW'(IX_BOOT):    rd_mux = boot_q;
      IW'(IX_COUNT):   rd_mux = cnt_val;
      IW'(IX_FLAG):    rd_mux = sc_q[0];
      IW'(IX_NVFLAG):  rd_mux = sc_q[1];
      IW'(IX_IRQ_ST):  rd_mux = irq_st;
      IW'(IX_IRQ_RAW): rd_mux = lvl_w;
      IW'(IX_IRQ_EN):  rd_mux = sc_q[2];
      IW'(IX_SW_SET):  rd_mux = lvl_w;
      IW'(IX_FIQ_ST):  rd_mux = fiq_st;
      IW'(IX_FIQ_RAW): rd_mux = lvl_w;
      IW'(IX_FIQ_EN):  rd_mux = sc_q[3];
      default:         rd_mux = '0;
    endcase
  end

  assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;
endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              ref_tick,
  input logic              remap_sel,
  input logic              rst_req,
  input logic              int_req,
  input logic [31:0]       osc_val,
  input logic              lock_open,
  input logic [31:0]       cnt_val
);
  logic wr_osc, wr_ctrl;
  assign wr_osc  = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));

  // R3: a locked oscillator write leaves the value alone
  p_osc_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_osc && !lock_open) |=> $stable(osc_val));

  // R4: remap only rises after a control write carrying bit 2
  p_remap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remap_sel) |-> $past(wr_ctrl && bus_wdata[2]));

  // R5: each reset request traces to a control write with bit 3
  p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_ctrl && bus_wdata[3]));

  // R7: counter steps on tick and holds without it
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> (cnt_val == $past(cnt_val) + 32'd1));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(cnt_val));

  // R11: the interrupt line only rises after a bus write
  p_int_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> $past(bus_sel && bus_wr));
endmodule

bind cm_sysctl cm_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ref_tick  (ref_tick),
  .remap_sel (remap_sel),
  .rst_req   (rst_req),
  .int_req   (int_req),
  .osc_val   (osc_val),
  .lock_open (lock_open),
  .cnt_val   (cnt_val)
);

// File: tb/cm_sysctl_test.sv
module cm_sysctl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, ref_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        led_on, remap_sel, rst_req, int_req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cm_sysctl #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .led_on(led_on), .remap_sel(remap_sel),
    .rst_req(rst_req), .int_req(int_req));

  // expected state, built from the requirements
  logic [15:0] m_key;
  logic [31:0] m_osc, m_aux, m_boot, m_flag, m_nv, m_ie, m_fe, m_cnt;
  logic        m_led, m_remap, m_lvl;

  function automatic void model_reset();
    m_key = 16'h0; m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF;
    m_boot = 32'h0000_0112; m_flag = 0; m_nv = 0; m_ie = 0; m_fe = 0;
    m_cnt = 0; m_led = 0; m_remap = 0; m_lvl = 0;
  endfunction

  function automatic void model_write(int ix, logic [31:0] d);
    bit open = (m_key == 16'hA05F);
    case (ix)
      2:  if (open) m_osc = d;
      3:  begin m_led = d[0]; m_remap = d[2]; end
      5:  m_key = d[15:0];
      7:  if (open) m_aux = d;
      9:  m_boot = d;
      12: m_flag |= d;   13: m_flag &= ~d;
      14: m_nv |= d;     15: m_nv &= ~d;
      18: m_ie |= d;     19: m_ie &= ~d;
      26: m_fe |= d;     27: m_fe &= ~d;
      20: if (d[0]) m_lvl = 1'b1;
      21: if (d[0]) m_lvl = 1'b0;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int ix);
    logic [31:0] lv = {31'b0, m_lvl};
    case (ix)
      2:  return m_osc;
      3:  return {28'b0, 1'b0, m_remap, 1'b0, m_led};
      5:  return {15'b0, m_key != 16'hA05F, m_key};
      7:  return m_aux;
      8:  return 32'h0001_1122;
      9:  return m_boot;
      10: return m_cnt;
      12: return m_flag;
      14: return m_nv;
      16: return lv & m_ie;
      17, 20, 25: return lv;
      18: return m_ie;
      24: return lv & m_fe;
      26: return m_fe;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_int();
    return m_lvl & (m_ie[0] | m_fe[0]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(int ix, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'(ix << 2); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_write(ix, d);
  endtask

  task automatic bread(int ix, output logic [31:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'(ix << 2);
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic rd_chk(string req, int ix);
    logic [31:0] v;
    bread(ix, v);
    chk(req, v, exp_rd(ix));
  endtask

  task automatic out_chk(string req);
    chk({req, " led"},   {31'b0, led_on},    {31'b0, m_led});
    chk({req, " remap"}, {31'b0, remap_sel}, {31'b0, m_remap});
    chk({req, " int"},   {31'b0, int_req},   {31'b0, exp_int()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d;
    void'($urandom(32'd7319));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state; R12 unmapped zero
    for (int i = 0; i < 64; i++) rd_chk("R1/R12 reset read", i);
    out_chk("R1");
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

    // R2 key; R3 gated oscillators
    bwrite(5, 32'h1234_A05F); rd_chk("R2 key open", 5);
    bwrite(2, 32'hDEAD_0001); rd_chk("R3 osc open", 2);
    bwrite(7, 32'h0000_BEEF); rd_chk("R3 aux open", 7);
    bwrite(5, 32'h0000_0005); rd_chk("R2 key locked", 5);
    bwrite(2, 32'h1111_2222); rd_chk("R3 osc locked", 2);
    bwrite(7, 32'h3333_4444); rd_chk("R3 aux locked", 7);

    // R4 control bits
    bwrite(3, 32'hFFFF_FFF7); rd_chk("R4 ctrl", 3); out_chk("R4");
    bwrite(3, 32'h0000_0001); rd_chk("R4 ctrl led", 3); out_chk("R4");

    // R5 reset pulse exactly one cycle after the write
    bwrite(3, 32'h0000_000C);
    chk("R5 pulse high", {31'b0, rst_req}, 32'h1);
    rd_chk("R5 bit3 reads 0", 3);
    @(negedge clk);
    chk("R5 pulse low", {31'b0, rst_req}, 32'h0);

    // R6 set/clear flags
    bwrite(12, 32'h0000_F0F0); bwrite(13, 32'h0000_3000);
    rd_chk("R6 flags", 12); rd_chk("R6 clear idx reads 0", 13);
    bwrite(14, 32'h8000_0003); bwrite(15, 32'h0000_0001);
    rd_chk("R6 nvflags", 14);

    // R7 counter
    ref_tick = 1; m_cnt += 5;
    repeat (5) @(negedge clk);
    ref_tick = 0;
    rd_chk("R7 count step", 10);
    repeat (3) @(negedge clk);
    rd_chk("R7 count hold", 10);

    // R8-R11 interrupt source
    bwrite(18, 32'h0000_0003); rd_chk("R8 irq mask", 18);
    out_chk("R11 masked, no level");
    bwrite(20, 32'h0000_0001);
    rd_chk("R9 level", 20); rd_chk("R9 raw17", 17); rd_chk("R9 raw25", 25);
    rd_chk("R10 irq status", 16); out_chk("R11 irq");
    bwrite(19, 32'h0000_0001); rd_chk("R8 irq clear", 18);
    rd_chk("R10 irq status masked", 16); out_chk("R11 none");
    bwrite(26, 32'h0000_0001); rd_chk("R8 fiq mask", 26);
    rd_chk("R10 fiq status", 24); out_chk("R11 fiq");
    bwrite(27, 32'h0000_0001); bwrite(26, 32'h0000_0001);
    bwrite(21, 32'h0000_0001); rd_chk("R9 level clear", 20);
    out_chk("R11 level low");

    // R12 read-only and unmapped writes
    bwrite(8, 32'hFFFF_FFFF); bwrite(4, 32'hFFFF_FFFF);
    bwrite(30, 32'hFFFF_FFFF); bwrite(9, 32'hABCD_0123);
    for (int i = 0; i < 32; i++) rd_chk("R12 sweep", i);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int ix = int'($urandom % 32);
      d = $urandom;
      if (ix == 5 && ($urandom % 3) == 0) d[15:0] = 16'hA05F;
      if (ix == 3) d[3] = 1'b0;
      bwrite(ix, d);
      rd_chk("R3/R6/R8/R9 random", int'($urandom % 32));
      out_chk("R4/R11 random");
    end
    for (int i = 0; i < 32; i++) rd_chk("R12 final sweep", i);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule